// File: doc/BRIEF.md
# Double-Word Instruction Fetch Unit

This block feeds a decoder with one instruction per clock for a processor whose instructions are one or two words long. The code store is read as an aligned pair of words per cycle. A word pointer selects the pair, and the unit decodes which part of that pair forms the current instruction. The selected instruction is then registered towards the decoder, and the pointer moves past it.

A word whose top bit is set starts a long instruction. The code is laid out so that every long instruction begins at an even word address. When a short instruction sits in the low half of a pair and the high half is the all-zeros padding word, the pointer jumps over the padding, so padding costs no cycle. A branch request loads a new word pointer. The instruction decoded in that cycle is dropped.

Top module: `dw_fetch`

## Requirements
- R1: While reset is held, `inst_valid` is 0 and the pointer equals `RESET_ADDR`. On the first clock edge after reset is released, the instruction at `RESET_ADDR` is issued.
- R2: `code_addr` is the pointer with its least significant bit removed. `code_data` bits [WORD_W-1:0] hold the even word of the pair and bits [2*WORD_W-1:WORD_W] hold the odd word.
- R3: A word at an even pointer with bit WORD_W-1 clear, followed by a non-zero odd word, is issued as a short instruction, and the pointer advances by 1.
- R4: A short instruction at an even pointer whose odd partner word is 0x0000 is issued, and the pointer advances by 2. The padding word is never issued.
- R5: A word at an even pointer with bit WORD_W-1 set is issued as a long instruction, with `inst_long`=1, `inst_word0`=even word and `inst_word1`=odd word. The pointer advances by 2.
- R6: At an odd pointer the odd word is issued as a short instruction and the pointer advances by 1, whatever its top bit.
- R7: With no branch request, `inst_valid` is 1 on every cycle after the first edge out of reset.
- R8: When `br_valid` is high at a clock edge, the instruction decoded in that cycle is dropped (`inst_valid`=0 after that edge) and the pointer becomes `br_target`. Of back-to-back requests, the last one wins.
- R9: `inst_addr` is the word address of the first word of the issued instruction.
- R10: A short instruction presents `inst_word1` = 0.
- R11: A zero word that is itself the current instruction is issued as a short no-op. This applies both at an even pointer and as a branch target at an odd pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_addr | output | ADDR_W-1 | Pair index into the code store |
| code_data | input | 2*WORD_W | Word pair returned by the store in the same cycle |
| br_valid | input | 1 | Branch request |
| br_target | input | ADDR_W | Branch target word address |
| inst_valid | output | 1 | Issued instruction is valid |
| inst_long | output | 1 | Issued instruction is two words long |
| inst_word0 | output | WORD_W | First word of the instruction |
| inst_word1 | output | WORD_W | Second word (long only, else 0) |
| inst_addr | output | ADDR_W | Word address of the instruction |

## Verification
The instruction at the current pointer appears on the outputs one clock edge after the pointer holds that address, and `code_addr` follows the pointer in the same cycle. A branch request gives an invalid output after the edge that samples it, and the target instruction appears after the following edge. The bench drives inputs and samples outputs on the falling edge, one falling edge per expected issue slot. It therefore compares each issued instruction, bubble and pair address in exactly the cycle these latencies predict.

// File: rtl/dw_fetch_pkg.sv
package dw_fetch_pkg;
    typedef enum logic {
        ADV_ONE = 1'b0,
        ADV_TWO = 1'b1
    } adv_e;
endpackage

// File: rtl/dw_fetch_pair_decode.sv
module dw_fetch_pair_decode
    import dw_fetch_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter bit SKIP_PAD = 1'b1
) (
    input  logic [2*WORD_W-1:0] pair,
    input  logic                odd,
    output logic [WORD_W-1:0]   sel_word,
    output logic [WORD_W-1:0]   second_word,
    output logic                is_long,
    output adv_e                adv
);
    logic [WORD_W-1:0] lo_w;
    logic [WORD_W-1:0] hi_w;
    logic              hi_is_pad;

    assign lo_w = pair[WORD_W-1:0];
    assign hi_w = pair[2*WORD_W-1:WORD_W];

    generate
        if (SKIP_PAD) begin : g_skip
            assign hi_is_pad = (hi_w == '0);
        end else begin : g_noskip
            assign hi_is_pad = 1'b0;
        end
    endgenerate

    always_comb begin
        sel_word    = odd ? hi_w : lo_w;
        is_long     = !odd && lo_w[WORD_W-1];
        second_word = is_long ? hi_w : '0;
        if (odd) begin
            adv = ADV_ONE;
        end else if (is_long || hi_is_pad) begin
            adv = ADV_TWO;
        end else begin
            adv = ADV_ONE;
        end
    end
endmodule

// File: rtl/dw_fetch_ptr_next.sv
module dw_fetch_ptr_next
    import dw_fetch_pkg::*;
#(
    parameter int PTR_W = 12
) (
    input  logic [PTR_W-1:0] ptr,
    input  adv_e             adv,
    input  logic             br_valid,
    input  logic [PTR_W-1:0] br_target,
    output logic [PTR_W-1:0] ptr_nxt
);
    logic [PTR_W-1:0] step;

    assign step = (adv == ADV_TWO) ? PTR_W'(2) : PTR_W'(1);

    always_comb begin
        if (br_valid) begin
            ptr_nxt = br_target;
        end else begin
            ptr_nxt = ptr + step;
        end
    end
endmodule

// File: rtl/dw_fetch.sv
module dw_fetch
    import dw_fetch_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          ADDR_W     = 12,
    parameter bit          SKIP_PAD   = 1'b1,
    parameter logic [11:0] RESET_ADDR = 12'd0
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-2:0]   code_addr,
    input  logic [2*WORD_W-1:0] code_data,
    input  logic                br_valid,
    input  logic [ADDR_W-1:0]   br_target,
    output logic                inst_valid,
    output logic                inst_long,
    output logic [WORD_W-1:0]   inst_word0,
    output logic [WORD_W-1:0]   inst_word1,
    output logic [ADDR_W-1:0]   inst_addr
);
    localparam logic [ADDR_W-1:0] RST_PTR = ADDR_W'(RESET_ADDR);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              valid;
        logic              is_long;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [ADDR_W-1:0] addr;
    } fetch_st_t;

    fetch_st_t st_d, st_q;

    logic [WORD_W-1:0] dec_word;
    logic [WORD_W-1:0] dec_second;
    logic              dec_long;
    adv_e              dec_adv;
    logic [ADDR_W-1:0] ptr_nxt;

    assign code_addr = st_q.ptr[ADDR_W-1:1];

    dw_fetch_pair_decode #(
        .WORD_W   (WORD_W),
        .SKIP_PAD (SKIP_PAD)
    ) u_dec (
        .pair        (code_data),
        .odd         (st_q.ptr[0]),
        .sel_word    (dec_word),
        .second_word (dec_second),
        .is_long     (dec_long),
        .adv         (dec_adv)
    );

    dw_fetch_ptr_next #(
        .PTR_W (ADDR_W)
    ) u_ptr (
        .ptr       (st_q.ptr),
        .adv       (dec_adv),
        .br_valid  (br_valid),
        .br_target (br_target),
        .ptr_nxt   (ptr_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ptr     = ptr_nxt;
        st_d.valid   = !br_valid;
        st_d.is_long = dec_long;
        st_d.w0      = dec_word;
        st_d.w1      = dec_second;
        st_d.addr    = st_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr     <= RST_PTR;
            st_q.valid   <= 1'b0;
            st_q.is_long <= 1'b0;
            st_q.w0      <= '0;
            st_q.w1      <= '0;
            st_q.addr    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inst_valid = st_q.valid;
    assign inst_long  = st_q.is_long;
    assign inst_word0 = st_q.w0;
    assign inst_word1 = st_q.w1;
    assign inst_addr  = st_q.addr;

    a_r7_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> inst_valid);

    a_r8_branch_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (!inst_valid && st_q.ptr == $past(br_target)));

    a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> ((st_q.ptr - $past(st_q.ptr)) == ADDR_W'(1)
                    || (st_q.ptr - $past(st_q.ptr)) == ADDR_W'(2)));

    a_r5_long_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && inst_long) |-> !inst_addr[0]);

    a_r10_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && !inst_long) |-> (inst_word1 == '0));

    a_r5_long_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !st_q.ptr[0] && code_data[WORD_W-1]) |=>
            (st_q.ptr == $past(st_q.ptr) + ADDR_W'(2)));
endmodule

// File: tb/dw_fetch_tb_top.sv
`timescale 1ns/1ps
module dw_fetch_tb_top;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 6;
    localparam int PAIRS  = 1 << (ADDR_W - 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-2:0]   code_addr;
    logic [2*WORD_W-1:0] code_data;
    logic                br_valid = 1'b0;
    logic [ADDR_W-1:0]   br_target = '0;
    logic                inst_valid;
    logic                inst_long;
    logic [WORD_W-1:0]   inst_word0;
    logic [WORD_W-1:0]   inst_word1;
    logic [ADDR_W-1:0]   inst_addr;

    logic [2*WORD_W-1:0] mem [PAIRS];
    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    assign code_data = mem[code_addr];

    dw_fetch #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_addr  (code_addr),
        .code_data  (code_data),
        .br_valid   (br_valid),
        .br_target  (br_target),
        .inst_valid (inst_valid),
        .inst_long  (inst_long),
        .inst_word0 (inst_word0),
        .inst_word1 (inst_word1),
        .inst_addr  (inst_addr)
    );

    task automatic set_word(input int a, input logic [WORD_W-1:0] v);
        if (a % 2 == 0) mem[a/2][WORD_W-1:0] = v;
        else            mem[a/2][2*WORD_W-1:WORD_W] = v;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_issue(input string tag, input int a, input logic [WORD_W-1:0] w0,
                                input logic [WORD_W-1:0] w1, input logic lg);
        @(negedge clk);
        check({tag, " valid"}, 64'(inst_valid), 64'(1));
        check({tag, " addr R9"}, 64'(inst_addr), 64'(a));
        check({tag, " word0"}, 64'(inst_word0), 64'(w0));
        check({tag, " word1 R10"}, 64'(inst_word1), 64'(w1));
        check({tag, " long"}, 64'(inst_long), 64'(lg));
    endtask

    task automatic do_branch(input int t);
        br_valid  = 1'b1;
        br_target = ADDR_W'(t);
        @(negedge clk);
        br_valid = 1'b0;
        check("R8 bubble after branch", 64'(inst_valid), 64'(0));
    endtask

    task automatic t_reset_and_stream();
        check("R1 valid low in reset", 64'(inst_valid), 64'(0));
        check("R2 code_addr in reset", 64'(code_addr), 64'(0));
        rst_n = 1'b1;
        expect_issue("R1 R3 first short", 0, 16'h0101, 16'h0000, 1'b0);
        expect_issue("R6 odd short", 1, 16'h0102, 16'h0000, 1'b0);
        expect_issue("R5 long", 2, 16'h8003, 16'h1234, 1'b1);
        expect_issue("R4 short before pad", 4, 16'h0104, 16'h0000, 1'b0);
        check("R2 pair index after skip", 64'(code_addr), 64'(3));
        expect_issue("R4 R7 after pad", 6, 16'h0105, 16'h0000, 1'b0);
        expect_issue("R7 next", 7, 16'h0106, 16'h0000, 1'b0);
    endtask

    task automatic t_odd_top_bit();
        do_branch(9);
        expect_issue("R6 odd top bit short", 9, 16'h8888, 16'h0000, 1'b0);
        expect_issue("R6 after odd", 10, 16'h0107, 16'h0000, 1'b0);
    endtask

    task automatic t_zero_even();
        do_branch(12);
        expect_issue("R11 zero at even", 12, 16'h0000, 16'h0000, 1'b0);
        expect_issue("R11 after zero", 13, 16'h0109, 16'h0000, 1'b0);
    endtask

    task automatic t_odd_zero_target();
        do_branch(15);
        expect_issue("R11 zero odd target", 15, 16'h0000, 16'h0000, 1'b0);
        expect_issue("R4 short then pad", 16, 16'h010A, 16'h0000, 1'b0);
        expect_issue("R5 long after pad", 18, 16'h8ABC, 16'h00FF, 1'b1);
        expect_issue("R5 advance by two", 20, 16'h0111, 16'h0000, 1'b0);
    endtask

    task automatic t_back_to_back_branch();
        br_valid  = 1'b1;
        br_target = ADDR_W'(0);
        @(negedge clk);
        check("R8 first branch bubble", 64'(inst_valid), 64'(0));
        br_target = ADDR_W'(6);
        @(negedge clk);
        br_valid = 1'b0;
        check("R8 second branch bubble", 64'(inst_valid), 64'(0));
        expect_issue("R8 last target wins", 6, 16'h0105, 16'h0000, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < PAIRS; i++) mem[i] = '0;
        set_word(0, 16'h0101);  set_word(1, 16'h0102);
        set_word(2, 16'h8003);  set_word(3, 16'h1234);
        set_word(4, 16'h0104);  set_word(5, 16'h0000);
        set_word(6, 16'h0105);  set_word(7, 16'h0106);
        set_word(8, 16'h0001);  set_word(9, 16'h8888);
        set_word(10, 16'h0107); set_word(11, 16'h0108);
        set_word(12, 16'h0000); set_word(13, 16'h0109);
        set_word(14, 16'h0001); set_word(15, 16'h0000);
        set_word(16, 16'h010A); set_word(17, 16'h0000);
        set_word(18, 16'h8ABC); set_word(19, 16'h00FF);
        set_word(20, 16'h0111); set_word(21, 16'h0112);
        repeat (3) @(negedge clk);
        t_reset_and_stream();
        t_odd_top_bit();
        t_zero_even();
        t_odd_zero_target();
        t_back_to_back_branch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule